// File: doc/BRIEF.md
# Message Buffer Transfer Engine

This block moves the contents of one message object between four CPU-visible buffer registers and a word-organised message RAM. Each object takes four consecutive RAM words: identifier/arbitration, control/length, data bytes 0-3 and data bytes 4-7. The RAM has a single port and one cycle of read latency. It cannot store part of an object, so every store writes all four words.

The CPU loads the buffer registers while the engine is idle. It then issues a command carrying an object number, a direction and a four-bit field mask. A read command copies the selected fields from RAM into the buffer and leaves the other buffer fields as they were. A write command first reads the whole object. It refreshes every unselected buffer field from RAM and then writes all four buffer fields back, so the object changes only in the selected fields. A `busy` flag covers the whole command. A separate `transfer_active` flag is high only while the RAM port is in use, so that a transmit scheduler can hold off during that time.

Top module: `msgbuf_xfer`

## Requirements
- R1: A command accepted while idle raises `busy` on the next clock edge. `busy` stays high for 5 cycles for a read, 9 cycles for a write and 1 cycle for an invalid object.
- R2: A command presented while `busy` is high is ignored and starts no further transfer.
- R3: A read (`cmd_dir`=0) loads each buffer field whose mask bit is set with the matching RAM word. Mask bit 0 selects the arbitration field (word 0), bit 1 the control field (word 1), bit 2 data A (word 2) and bit 3 data B (word 3).
- R4: A read leaves every buffer field whose mask bit is clear at its previous value.
- R5: A write (`cmd_dir`=1) stores all four words of the object. Each selected word takes the buffer value, and each unselected word keeps the value it already held in RAM.
- R6: After a write, every unselected buffer field holds the RAM contents of that field, and every selected field keeps its buffer value.
- R7: While idle, `buf_we` loads `buf_wdata` into the field numbered by `buf_sel` (0 arbitration, 1 control, 2 data A, 3 data B). While `busy` is high, `buf_we` has no effect.
- R8: An object number of 0 or above 32 causes no RAM access and leaves the buffer and the RAM unchanged.
- R9: `transfer_active` is high for exactly the cycles in which the engine uses the RAM port: 5 cycles for a read, 9 for a write and none for an invalid object. It is never high while `busy` is low.
- R10: Word k of object n is at RAM address (n-1)*4+k. A read makes 4 RAM accesses, a write makes 8, and no access falls outside the object.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | Command strobe |
| cmd_obj | input | 6 | Object number; 1 to 32 are valid |
| cmd_dir | input | 1 | 0 = RAM to buffer, 1 = buffer to RAM |
| cmd_mask | input | 4 | Field select mask |
| buf_we | input | 1 | Buffer field write strobe |
| buf_sel | input | 2 | Buffer field number |
| buf_wdata | input | 32 | Buffer field write data |
| buf_arb | output | 32 | Arbitration field |
| buf_ctrl | output | 32 | Control field |
| buf_data_a | output | 32 | Data A field |
| buf_data_b | output | 32 | Data B field |
| busy | output | 1 | Command in progress |
| transfer_active | output | 1 | RAM port in use |
| ram_addr | output | 7 | RAM word address |
| ram_re | output | 1 | RAM read enable |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, valid one cycle after `ram_re` |

## Verification
`busy` must read high on the first falling edge after the edge that samples the command. The bench drives every input at a falling edge and samples at falling edges, counting consecutive high samples of `busy` and `transfer_active`. The expected counts are 5/5 for a read, 9/9 for a write and 1/0 for an invalid object. Buffer fields and the whole RAM image are compared with the bench's arithmetic model only after `busy` has fallen, because the last field capture lands on the edge that clears `busy`. The RAM accesses counted at rising edges are checked against the target object's four addresses. A second command and a buffer write are injected on the second busy cycle, and `busy` must then stay low for three further cycles.

// File: rtl/msgbuf_pkg.sv
package msgbuf_pkg;
  localparam int FIELDS = 4;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_DRAIN = 3'd2,
    ST_WR    = 3'd3,
    ST_ABORT = 3'd4
  } xfer_state_e;
endpackage

// File: rtl/msgbuf_seq.sv
module msgbuf_seq
  import msgbuf_pkg::*;
#(
  parameter int NUM_OBJ  = 32,
  parameter int OBJ_W    = 6,
  parameter int IDX_W    = 2,
  parameter int ADDR_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OBJ_W-1:0]  cmd_obj,
  input  logic              cmd_dir,
  input  logic [FIELDS-1:0] cmd_mask,
  output logic              busy,
  output logic              active,
  output logic              ram_re,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              dir_q,
  output logic [FIELDS-1:0] mask_q
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FIELDS - 1);

  xfer_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              accept, obj_ok, rd_pend_q;
  logic [IDX_W-1:0]  rd_idx_q;
  logic [OBJ_W-1:0]  obj_m1;

  assign obj_m1 = cmd_obj - OBJ_W'(1);
  assign obj_ok = (cmd_obj != '0) && (cmd_obj <= OBJ_W'(NUM_OBJ));
  assign accept = (state_q == ST_IDLE) && cmd_valid;
  assign base_d = {obj_m1[ADDR_W-IDX_W-1:0], {IDX_W{1'b0}}};

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        if (cmd_valid) state_d = obj_ok ? ST_RD : ST_ABORT;
      end
      ST_RD: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_DRAIN;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      ST_DRAIN: begin
        idx_d   = '0;
        state_d = dir_q ? ST_WR : ST_IDLE;
      end
      ST_WR: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      rd_pend_q <= 1'b0;
      rd_idx_q  <= '0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      rd_pend_q <= ram_re;
      rd_idx_q  <= idx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      dir_q  <= 1'b0;
      mask_q <= '0;
    end else if (accept) begin
      base_q <= base_d;
      dir_q  <= cmd_dir;
      mask_q <= cmd_mask;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign active   = busy && (state_q != ST_ABORT);
  assign ram_re   = (state_q == ST_RD);
  assign ram_we   = (state_q == ST_WR);
  assign ram_addr = base_q + ADDR_W'(idx_q);
  assign word_idx = idx_q;
  assign cap_en   = rd_pend_q;
  assign cap_idx  = rd_idx_q;

  assert_abort_no_ram_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT) |-> (!ram_re && !ram_we));
  assert_abort_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT) |=> (state_q == ST_IDLE));
  assert_cmd_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(base_q) && $stable(dir_q) && $stable(mask_q)));
  assert_read_then_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && idx_q == LAST_IDX) |=> (state_q == ST_DRAIN && cap_en));
endmodule

// File: rtl/msgbuf_regs.sv
module msgbuf_regs
  import msgbuf_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     busy,
  input  logic                     buf_we,
  input  logic [IDX_W-1:0]         buf_sel,
  input  logic [WORD_W-1:0]        buf_wdata,
  input  logic                     cap_en,
  input  logic [IDX_W-1:0]         cap_idx,
  input  logic                     cap_dir,
  input  logic [FIELDS-1:0]        cap_mask,
  input  logic [WORD_W-1:0]        ram_rdata,
  input  logic [IDX_W-1:0]         word_idx,
  output logic [WORD_W-1:0]        ram_wdata,
  output logic [FIELDS*WORD_W-1:0] buf_flat
);
  logic [WORD_W-1:0] fld_q [FIELDS];

  for (genvar k = 0; k < FIELDS; k++) begin : g_field
    logic wr_hit, cap_hit, fld_en;
    logic [WORD_W-1:0] fld_d;

    assign wr_hit  = buf_we && !busy && (buf_sel == IDX_W'(k));
    assign cap_hit = cap_en && (cap_idx == IDX_W'(k)) &&
                     (cap_dir ? !cap_mask[k] : cap_mask[k]);
    assign fld_en  = wr_hit || cap_hit;
    assign fld_d   = wr_hit ? buf_wdata : ram_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q[k] <= '0;
      end else if (fld_en) begin
        fld_q[k] <= fld_d;
      end
    end

    assign buf_flat[k*WORD_W +: WORD_W] = fld_q[k];
  end

  assign ram_wdata = fld_q[word_idx];

  assert_busy_blocks_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cap_en) |=> $stable(buf_flat));
  assert_read_keeps_unselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !cap_dir && !cap_mask[cap_idx]) |=> $stable(buf_flat));
endmodule

// File: rtl/msgbuf_xfer.sv
module msgbuf_xfer
  import msgbuf_pkg::*;
#(
  parameter int NUM_OBJ   = 32,
  parameter int WORD_W    = 32,
  localparam int OBJ_IX_W = $clog2(NUM_OBJ),
  localparam int OBJ_W    = OBJ_IX_W + 1,
  localparam int IDX_W    = $clog2(FIELDS),
  localparam int ADDR_W   = OBJ_IX_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OBJ_W-1:0]  cmd_obj,
  input  logic              cmd_dir,
  input  logic [FIELDS-1:0] cmd_mask,
  input  logic              buf_we,
  input  logic [IDX_W-1:0]  buf_sel,
  input  logic [WORD_W-1:0] buf_wdata,
  output logic [WORD_W-1:0] buf_arb,
  output logic [WORD_W-1:0] buf_ctrl,
  output logic [WORD_W-1:0] buf_data_a,
  output logic [WORD_W-1:0] buf_data_b,
  output logic              busy,
  output logic              transfer_active,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_re,
  output logic              ram_we,
  output logic [WORD_W-1:0] ram_wdata,
  input  logic [WORD_W-1:0] ram_rdata
);
  logic [1:0]               rst_sync_q;
  logic                     rst_int_n;
  logic [IDX_W-1:0]         word_idx, cap_idx;
  logic                     cap_en, dir_q;
  logic [FIELDS-1:0]        mask_q;
  logic [FIELDS*WORD_W-1:0] buf_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  msgbuf_seq #(
    .NUM_OBJ(NUM_OBJ), .OBJ_W(OBJ_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) i_seq (
    .clk(clk), .rst_n(rst_int_n),
    .cmd_valid(cmd_valid), .cmd_obj(cmd_obj), .cmd_dir(cmd_dir), .cmd_mask(cmd_mask),
    .busy(busy), .active(transfer_active),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .word_idx(word_idx), .cap_en(cap_en), .cap_idx(cap_idx),
    .dir_q(dir_q), .mask_q(mask_q)
  );

  msgbuf_regs #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_regs (
    .clk(clk), .rst_n(rst_int_n), .busy(busy),
    .buf_we(buf_we), .buf_sel(buf_sel), .buf_wdata(buf_wdata),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_dir(dir_q), .cap_mask(mask_q),
    .ram_rdata(ram_rdata), .word_idx(word_idx),
    .ram_wdata(ram_wdata), .buf_flat(buf_flat)
  );

  assign buf_arb    = buf_flat[0*WORD_W +: WORD_W];
  assign buf_ctrl   = buf_flat[1*WORD_W +: WORD_W];
  assign buf_data_a = buf_flat[2*WORD_W +: WORD_W];
  assign buf_data_b = buf_flat[3*WORD_W +: WORD_W];

  assert_idle_no_ram_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy |-> (!ram_re && !ram_we && !transfer_active));
  assert_busy_needs_cmd_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(busy) |-> $past(cmd_valid));
  assert_single_port_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(ram_re && ram_we));
  assert_write_after_read_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ram_we) |-> $past(transfer_active) && !$past(ram_re));
endmodule

// File: tb/test_msgbuf_xfer.sv
`timescale 1ns/1ps
module test_msgbuf_xfer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_dir, buf_we;
  logic [5:0]  cmd_obj;
  logic [3:0]  cmd_mask;
  logic [1:0]  buf_sel;
  logic [31:0] buf_wdata, ram_rdata, ram_wdata;
  logic [31:0] buf_arb, buf_ctrl, buf_data_a, buf_data_b;
  logic        busy, transfer_active, ram_re, ram_we;
  logic [6:0]  ram_addr;

  int checks = 0;
  int failures = 0;
  logic [31:0] mem [128];
  logic [31:0] exp_mem [128];
  logic [31:0] exp_buf [4];
  int acc_cnt, bad_addr, exp_lo, exp_hi;

  always #4 clk = ~clk;

  msgbuf_xfer i_msgbuf_xfer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_obj(cmd_obj),
    .cmd_dir(cmd_dir), .cmd_mask(cmd_mask), .buf_we(buf_we), .buf_sel(buf_sel),
    .buf_wdata(buf_wdata), .buf_arb(buf_arb), .buf_ctrl(buf_ctrl),
    .buf_data_a(buf_data_a), .buf_data_b(buf_data_b), .busy(busy),
    .transfer_active(transfer_active), .ram_addr(ram_addr), .ram_re(ram_re),
    .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
    if (ram_re || ram_we) begin
      acc_cnt <= acc_cnt + 1;
      if (int'(ram_addr) < exp_lo || int'(ram_addr) > exp_hi) bad_addr <= bad_addr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bufword(input int k);
    case (k)
      0: return buf_arb;
      1: return buf_ctrl;
      2: return buf_data_a;
      default: return buf_data_b;
    endcase
  endfunction

  task automatic check_state(input string req);
    int diff = 0;
    for (int k = 0; k < 4; k++)
      chk(bufword(k) === exp_buf[k], req, $sformatf("buffer field %0d", k), bufword(k), exp_buf[k]);
    for (int a = 0; a < 128; a++) if (mem[a] !== exp_mem[a]) diff++;
    chk(diff == 0, req, "RAM words differing", diff, 0);
  endtask

  task automatic load_buf(input int obj, input int mask, input int dir);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      buf_we = 1'b1; buf_sel = 2'(k);
      buf_wdata = 32'hB000_0000 | (obj << 16) | (mask << 8) | (dir << 4) | k;
      exp_buf[k] = buf_wdata;
    end
    @(negedge clk);
    buf_we = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++)
      chk(bufword(k) === exp_buf[k], "R7", "idle buffer write", bufword(k), exp_buf[k]);
  endtask

  task automatic run_cmd(input int obj, input int mask, input int dir);
    int n = 0, ta = 0, rb = 0;
    bit valid = (obj >= 1 && obj <= 32);
    int base = (obj - 1) * 4;
    exp_lo = valid ? base : 1000; exp_hi = valid ? base + 3 : -1;
    acc_cnt = 0; bad_addr = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_obj = 6'(obj); cmd_dir = dir[0]; cmd_mask = 4'(mask);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (busy && n < 40) begin
      ta += int'(transfer_active);
      if (n == 1) begin
        cmd_valid = 1'b1; cmd_obj = 6'((obj % 32) + 1); cmd_dir = ~dir[0]; cmd_mask = ~4'(mask);
        buf_we = 1'b1; buf_sel = 2'(mask); buf_wdata = 32'hDEAD_BEEF;
      end else begin
        cmd_valid = 1'b0; buf_we = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    cmd_valid = 1'b0; buf_we = 1'b0;
    chk(n == (!valid ? 1 : (dir != 0 ? 9 : 5)), "R1", "busy cycles", n, !valid ? 1 : (dir != 0 ? 9 : 5));
    chk(ta == (!valid ? 0 : (dir != 0 ? 9 : 5)), "R9", "transfer_active cycles", ta, !valid ? 0 : (dir != 0 ? 9 : 5));
    for (int i = 0; i < 3; i++) begin
      rb += int'(busy);
      @(negedge clk);
    end
    chk(rb == 0, "R2", "busy after ignored command", rb, 0);
    chk(acc_cnt == (!valid ? 0 : (dir != 0 ? 8 : 4)), valid ? "R10" : "R8", "RAM accesses", acc_cnt, !valid ? 0 : (dir != 0 ? 8 : 4));
    chk(bad_addr == 0, "R10", "accesses outside object", bad_addr, 0);
    if (valid) begin
      for (int k = 0; k < 4; k++) begin
        if (dir == 0) begin
          if (mask[k]) exp_buf[k] = exp_mem[base + k];
        end else begin
          if (!mask[k]) exp_buf[k] = exp_mem[base + k];
          exp_mem[base + k] = exp_buf[k];
        end
      end
    end
    if (!valid) check_state("R8");
    else if (dir == 0) check_state(mask == 15 ? "R3" : "R3 R4");
    else check_state("R5 R6");
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int objs [4] = '{1, 2, 17, 32};
    int bad [3] = '{0, 33, 63};
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_obj = '0; cmd_dir = 1'b0; cmd_mask = '0;
    buf_we = 1'b0; buf_sel = '0; buf_wdata = '0;
    for (int a = 0; a < 128; a++) begin
      mem[a] = 32'hC0DE_0000 ^ (a * 32'h0100_0193);
      exp_mem[a] = mem[a];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
    chk(transfer_active === 1'b0, "R9", "active after reset", transfer_active, 0);
    chk(buf_arb === 32'h0, "R7", "arb field after reset", buf_arb, 0);
    chk(!ram_re && !ram_we, "R10", "RAM strobes after reset", {ram_re, ram_we}, 0);
    for (int k = 0; k < 4; k++) exp_buf[k] = '0;
    foreach (objs[i])
      for (int m = 0; m < 16; m++)
        for (int d = 0; d < 2; d++) begin
          load_buf(objs[i], m, d);
          run_cmd(objs[i], m, d);
        end
    foreach (bad[i]) begin
      load_buf(bad[i], 15, 1);
      run_cmd(bad[i], 15, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule